// File: doc/BRIEF.md
# Move and Shift Execute Unit with Condition Flags

This unit is the execute-stage slice of a 32-bit processor that handles the move family. It copies an operand to a destination, writes its bitwise inverse, loads a zero-extended 16-bit constant, or passes a register through a five-way shifter. The five shifts are logical left, logical right, arithmetic right, rotate right, and a one-place rotate through the carry flag. The shift amount is either a small immediate or the low byte of a second register. Decode, condition evaluation and the register file sit outside the unit. It receives an already decoded operation together with the current flag values.

Each accepted operation produces a result and the next negative, zero, carry and overflow flags. When the destination is the program counter, it also raises a branch request with an even target address. Combinations that the architecture forbids raise an illegal flag and change no state. A stack-pointer source or a program-counter destination is only allowed in one form: a plain, unshifted register move that does not set flags. All outputs are registered, one cycle after the operation is presented.

Top module: `mvx_exec`

## Requirements
- R1: With op_code 0 (move) and no shift requested, result equals src_val. This holds for both an immediate source and a register source.
- R2: With op_code 1 (inverted move), result is the bitwise NOT of the shifter output. An immediate 0x0000000F gives 0xFFFFFFF0.
- R3: With op_code 2 (wide immediate move), result is src_val[15:0] zero-extended to 32 bits. The source must be an unshifted immediate no larger than 65535; otherwise the operation is illegal.
- R4: shift_type 0 (LSL) and 1 (LSR) handle amounts as follows. For an amount n of 1 to 31, LSL carry is input bit 32-n and LSR carry is input bit n-1. At exactly 32 the result is 0, with carry equal to bit 0 (LSL) or bit 31 (LSR). Above 32 both result and carry are 0.
- R5: shift_type 2 (ASR) with n from 1 to 31 fills with the sign bit and takes carry from bit n-1. With n of 32 or more, every result bit and the carry equal the sign bit.
- R6: shift_type 3 (ROR) rotates by n modulo 32 and takes carry from result bit 31; a non-zero multiple of 32 leaves the value unchanged. shift_type 4 (RRX) shifts right by one, puts c_in into bit 31 and takes old bit 0 as carry.
- R7: A shift amount taken from a register (shift_from_reg=1) uses only shift_reg[7:0]; higher bits of shift_reg have no effect. Otherwise the amount is shift_imm.
- R8: With set_flags=1 and a legal operation, flag_n is result bit 31 and flag_z is 1 exactly when result is zero. With set_flags=0, flag_n, flag_z and flag_c equal n_in, z_in and c_in.
- R9: With set_flags=1, flag_c is the shifter carry-out. A shift amount of 0, an immediate source and the wide immediate move all leave flag_c equal to c_in.
- R10: flag_v always equals v_in.
- R11: With dest_is_pc=1 on a legal operation, branch_req is 1 and branch_tgt is the result with bit 0 cleared. Otherwise branch_req is 0.
- R12: illegal is 1 in any of these cases: op_code 3; shift_type 5 to 7; an immediate source with a shift requested; an immediate with src_is_sp; or dest_is_pc or src_is_sp on anything other than an unshifted register move (op_code 0) with set_flags=0. An illegal operation gives result 0 and no branch, and leaves the flags equal to their inputs. A shift is requested when shift_from_reg=1, shift_type is 4, or shift_imm is non-zero.
- R13: Outputs update on the rising edge that samples op_valid=1, and out_valid follows op_valid by one cycle. While rst_n is low at a clock edge, all outputs clear to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 2 | 0 move, 1 inverted move, 2 wide immediate move, 3 reserved |
| src_is_imm | input | 1 | Source operand is an immediate |
| src_is_sp | input | 1 | Source register is the stack pointer |
| src_val | input | 32 | Source operand value |
| shift_type | input | 3 | 0 LSL, 1 LSR, 2 ASR, 3 ROR, 4 RRX |
| shift_from_reg | input | 1 | Take shift amount from shift_reg |
| shift_imm | input | 5 | Immediate shift amount |
| shift_reg | input | 32 | Register holding the shift amount |
| set_flags | input | 1 | Update N, Z and C |
| n_in | input | 1 | Current negative flag |
| z_in | input | 1 | Current zero flag |
| c_in | input | 1 | Current carry flag |
| v_in | input | 1 | Current overflow flag |
| dest_is_pc | input | 1 | Destination is the program counter |
| out_valid | output | 1 | Outputs hold a new result |
| result | output | 32 | Value for the destination |
| flag_n | output | 1 | Next negative flag |
| flag_z | output | 1 | Next zero flag |
| flag_c | output | 1 | Next carry flag |
| flag_v | output | 1 | Next overflow flag |
| branch_req | output | 1 | Branch to branch_tgt |
| branch_tgt | output | 32 | Branch target, bit 0 clear |
| illegal | output | 1 | Forbidden operand combination |

## Verification
The hardest cases to reach are register-supplied amounts at the edges of the shifter. These are amounts of exactly 32, just above 32, a non-zero multiple of 32 for rotation, and amounts whose byte is small while the upper register bits are set. Uniform random stimulus almost never lands on them. The stimulus therefore draws shift_reg from a short list of edge amounts and sets random upper bits on top. Directed vectors cover each of these edges with a chosen carry input, so that the carry decision is visible at the ports.

// File: rtl/mvx_pkg.sv
// Shared encodings for the move/shift execute unit.
// Assumes a decoder upstream produces these codes.
package mvx_pkg;
    typedef enum logic [1:0] {
        OP_MOV  = 2'd0,
        OP_MVN  = 2'd1,
        OP_MOVW = 2'd2,
        OP_RSVD = 2'd3
    } mvx_op_e;

    typedef enum logic [2:0] {
        SH_LSL = 3'd0,
        SH_LSR = 3'd1,
        SH_ASR = 3'd2,
        SH_ROR = 3'd3,
        SH_RRX = 3'd4
    } mvx_shift_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } mvx_flags_t;
endpackage

// File: rtl/mvx_shifter.sv
// Five-type barrel shifter with carry-out.
// Assumes amount is the full unsigned shift count (immediate or register byte);
// amounts at or above XLEN follow the saturating rules, rotation wraps.
module mvx_shifter #(
    parameter int XLEN  = 32,
    parameter int AMT_W = 8
) (
    input  logic [XLEN-1:0]  operand,
    input  logic [2:0]       stype,
    input  logic [AMT_W-1:0] amount,
    input  logic             carry_in,
    output logic [XLEN-1:0]  shifted,
    output logic             carry_out
);
    import mvx_pkg::*;
    localparam int AW = $clog2(XLEN);

    logic          amt_zero;
    logic          amt_small;
    logic          amt_exact;
    logic [AW-1:0] lo;
    logic [AW-1:0] lo_neg;
    logic [AW-1:0] lo_m1;
    logic [XLEN-1:0] rot;

    // Classify the shift amount and derive bit indices.
    always_comb begin
        amt_zero  = (amount == '0);
        amt_small = (amount < AMT_W'(XLEN));
        amt_exact = (amount == AMT_W'(XLEN));
        lo        = amount[AW-1:0];
        lo_neg    = AW'(0) - lo;
        lo_m1     = lo - AW'(1);
        rot       = (lo == '0) ? operand : ((operand >> lo) | (operand << lo_neg));
    end

    // Select the shifted value and carry for the requested type.
    always_comb begin
        shifted   = operand;
        carry_out = carry_in;
        case (stype)
            SH_LSL: if (!amt_zero) begin
                if (amt_small) begin
                    shifted   = operand << lo;
                    carry_out = operand[lo_neg];
                end else begin
                    shifted   = '0;
                    carry_out = amt_exact ? operand[0] : 1'b0;
                end
            end
            SH_LSR: if (!amt_zero) begin
                if (amt_small) begin
                    shifted   = operand >> lo;
                    carry_out = operand[lo_m1];
                end else begin
                    shifted   = '0;
                    carry_out = amt_exact ? operand[XLEN-1] : 1'b0;
                end
            end
            SH_ASR: if (!amt_zero) begin
                if (amt_small) begin
                    shifted   = $unsigned($signed(operand) >>> lo);
                    carry_out = operand[lo_m1];
                end else begin
                    shifted   = {XLEN{operand[XLEN-1]}};
                    carry_out = operand[XLEN-1];
                end
            end
            SH_ROR: if (!amt_zero) begin
                shifted   = rot;
                carry_out = rot[XLEN-1];
            end
            SH_RRX: begin
                shifted   = {carry_in, operand[XLEN-1:1]};
                carry_out = operand[0];
            end
            default: begin
                shifted   = operand;
                carry_out = carry_in;
            end
        endcase
    end
endmodule

// File: rtl/mvx_legal.sv
// Legality check for move-family operand combinations.
// Assumes shift_req already reflects any shift request by the decoder.
module mvx_legal #(
    parameter int XLEN = 32,
    parameter int IMMW = 16
) (
    input  logic [1:0]      op_code,
    input  logic [2:0]      stype,
    input  logic            src_is_imm,
    input  logic            src_is_sp,
    input  logic [XLEN-1:0] src_val,
    input  logic            shift_req,
    input  logic            set_flags,
    input  logic            dest_is_pc,
    output logic            illegal
);
    import mvx_pkg::*;

    logic bad_op, bad_shift, bad_imm, bad_wide, bad_special;

    // Flag each forbidden combination separately, then merge.
    always_comb begin
        bad_op      = (op_code == OP_RSVD);
        bad_shift   = (stype > SH_RRX);
        bad_imm     = src_is_imm && (shift_req || src_is_sp);
        bad_wide    = (op_code == OP_MOVW) &&
                      (!src_is_imm || (src_val[XLEN-1:IMMW] != '0));
        bad_special = (dest_is_pc || src_is_sp) &&
                      ((op_code != OP_MOV) || src_is_imm || shift_req || set_flags);
        illegal     = bad_op | bad_shift | bad_imm | bad_wide | bad_special;
    end
endmodule

// File: rtl/mvx_flags.sv
// Next-flag logic: N/Z from result, C from shifter, V passed through.
// Assumes illegal operations must leave all flags as they were.
module mvx_flags #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0]      result,
    input  logic                 shift_c,
    input  logic                 keep_c,
    input  logic                 set_flags,
    input  logic                 illegal,
    input  mvx_pkg::mvx_flags_t  cur,
    output mvx_pkg::mvx_flags_t  nxt
);
    // Choose updated or held flags.
    always_comb begin
        nxt = cur;
        if (set_flags && !illegal) begin
            nxt.n = result[XLEN-1];
            nxt.z = (result == '0);
            nxt.c = keep_c ? cur.c : shift_c;
        end
    end
endmodule

// File: rtl/mvx_exec.sv
// Move/shift execute unit. Computes move, inverted move, wide immediate
// move and five shifts, with flag update and PC-write branch, registered
// one cycle after op_valid. Assumes decode and condition checks are upstream.
module mvx_exec #(
    parameter int XLEN  = 32,
    parameter int AMT_W = 8,
    parameter int IMMW  = 16,
    localparam int AW   = $clog2(XLEN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_valid,
    input  logic [1:0]      op_code,
    input  logic            src_is_imm,
    input  logic            src_is_sp,
    input  logic [XLEN-1:0] src_val,
    input  logic [2:0]      shift_type,
    input  logic            shift_from_reg,
    input  logic [AW-1:0]   shift_imm,
    input  logic [XLEN-1:0] shift_reg,
    input  logic            set_flags,
    input  logic            n_in,
    input  logic            z_in,
    input  logic            c_in,
    input  logic            v_in,
    input  logic            dest_is_pc,
    output logic            out_valid,
    output logic [XLEN-1:0] result,
    output logic            flag_n,
    output logic            flag_z,
    output logic            flag_c,
    output logic            flag_v,
    output logic            branch_req,
    output logic [XLEN-1:0] branch_tgt,
    output logic            illegal
);
    import mvx_pkg::*;

    logic [AMT_W-1:0] amount;
    logic             shift_req;
    logic [XLEN-1:0]  sh_val;
    logic             sh_c;
    logic             bad;
    logic [XLEN-1:0]  res_d;
    logic             keep_c;
    mvx_flags_t       cur_f, nxt_f;
    logic             unused_hi_bits;

    // Pick the shift amount source and note whether any shift is asked for.
    always_comb begin
        amount    = shift_from_reg ? shift_reg[AMT_W-1:0] : AMT_W'(shift_imm);
        shift_req = shift_from_reg || (shift_type == SH_RRX) || (shift_imm != '0);
    end
    assign unused_hi_bits = ^shift_reg[XLEN-1:AMT_W];

    mvx_shifter #(.XLEN(XLEN), .AMT_W(AMT_W)) u_shifter (
        .operand   (src_val),
        .stype     (shift_type),
        .amount    (amount),
        .carry_in  (c_in),
        .shifted   (sh_val),
        .carry_out (sh_c)
    );

    mvx_legal #(.XLEN(XLEN), .IMMW(IMMW)) u_legal (
        .op_code    (op_code),
        .stype      (shift_type),
        .src_is_imm (src_is_imm),
        .src_is_sp  (src_is_sp),
        .src_val    (src_val),
        .shift_req  (shift_req),
        .set_flags  (set_flags),
        .dest_is_pc (dest_is_pc),
        .illegal    (bad)
    );

    // Form the destination value for the selected operation.
    always_comb begin
        case (op_code)
            OP_MOV:  res_d = sh_val;
            OP_MVN:  res_d = ~sh_val;
            OP_MOVW: res_d = XLEN'(src_val[IMMW-1:0]);
            default: res_d = '0;
        endcase
        if (bad) res_d = '0;
        keep_c = src_is_imm || (op_code == OP_MOVW);
        cur_f  = '{n: n_in, z: z_in, c: c_in, v: v_in};
    end

    mvx_flags #(.XLEN(XLEN)) u_flags (
        .result    (res_d),
        .shift_c   (sh_c),
        .keep_c    (keep_c),
        .set_flags (set_flags),
        .illegal   (bad),
        .cur       (cur_f),
        .nxt       (nxt_f)
    );

    // Output register stage with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            result     <= '0;
            flag_n     <= 1'b0;
            flag_z     <= 1'b0;
            flag_c     <= 1'b0;
            flag_v     <= 1'b0;
            branch_req <= 1'b0;
            branch_tgt <= '0;
            illegal    <= 1'b0;
        end else begin
            out_valid <= op_valid;
            if (op_valid) begin
                result     <= res_d;
                flag_n     <= nxt_f.n;
                flag_z     <= nxt_f.z;
                flag_c     <= nxt_f.c;
                flag_v     <= nxt_f.v;
                branch_req <= dest_is_pc && !bad;
                branch_tgt <= (dest_is_pc && !bad) ? {res_d[XLEN-1:1], 1'b0} : '0;
                illegal    <= bad;
            end
        end
    end
endmodule

// File: rtl/mvx_exec_chk.sv
// Checker for mvx_exec: relates registered outputs to the inputs sampled
// one cycle earlier. Attached to every mvx_exec instance by bind.
module mvx_exec_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            op_valid,
    input logic [1:0]      op_code,
    input logic            set_flags,
    input logic            n_in,
    input logic            z_in,
    input logic            c_in,
    input logic            v_in,
    input logic            dest_is_pc,
    input logic            out_valid,
    input logic [XLEN-1:0] result,
    input logic            flag_n,
    input logic            flag_z,
    input logic            flag_c,
    input logic            flag_v,
    input logic            branch_req,
    input logic [XLEN-1:0] branch_tgt,
    input logic            illegal
);
    assert_movw_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !illegal && $past(op_code) == 2'd2) |-> (result[XLEN-1:16] == '0));

    assert_nz_track_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !illegal && $past(set_flags)) |->
        (flag_z == (result == '0)) && (flag_n == result[XLEN-1]));

    assert_flags_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(set_flags)) |->
        (flag_n == $past(n_in)) && (flag_z == $past(z_in)) && (flag_c == $past(c_in)));

    assert_overflow_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (flag_v == $past(v_in)));

    assert_branch_even_R11: assert property (@(posedge clk) disable iff (!rst_n)
        branch_req |-> (branch_tgt[0] == 1'b0) && (branch_tgt[XLEN-1:1] == result[XLEN-1:1]));

    assert_branch_only_pc_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && branch_req) |-> ($past(dest_is_pc) && !illegal));

    assert_illegal_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && illegal) |-> (!branch_req && result == '0 &&
        flag_n == $past(n_in) && flag_z == $past(z_in) && flag_c == $past(c_in)));

    assert_valid_latency_R13: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(op_valid)));
endmodule

bind mvx_exec mvx_exec_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/mvx_exec_bench.sv
// Bench: behavioural bit-at-a-time reference model updated each clock and
// compared against the unit's outputs on every falling edge.
module mvx_exec_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [1:0]  op_code = '0;
    logic        src_is_imm = 1'b0, src_is_sp = 1'b0;
    logic [31:0] src_val = '0;
    logic [2:0]  shift_type = '0;
    logic        shift_from_reg = 1'b0;
    logic [4:0]  shift_imm = '0;
    logic [31:0] shift_reg = '0;
    logic        set_flags = 1'b0, n_in = 1'b0, z_in = 1'b0, c_in = 1'b0, v_in = 1'b0;
    logic        dest_is_pc = 1'b0;
    logic        out_valid, flag_n, flag_z, flag_c, flag_v, branch_req, illegal;
    logic [31:0] result, branch_tgt;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string cur_tag = "R13";

    typedef struct {
        bit          valid;
        logic [31:0] res;
        bit          n, z, c, v, br, ill;
        logic [31:0] tgt;
        string       tag;
    } exp_t;
    exp_t model_q[$];
    exp_t exp_now;

    always #5 clk = ~clk;

    mvx_exec u_mvx_exec (.*);

    // Reference: one-bit-per-step shifting, written from the requirements.
    function automatic exp_t model_eval();
        exp_t e;
        logic [31:0] x;
        logic c, oldc;
        int amt;
        bit shreq, ill;
        e.valid = op_valid;
        e.tag   = cur_tag;
        amt   = shift_from_reg ? int'(shift_reg[7:0]) : int'(shift_imm);
        shreq = shift_from_reg || shift_type == 3'd4 || shift_imm != 0;
        ill = 0;
        if (op_code == 2'd3) ill = 1;
        if (shift_type > 3'd4) ill = 1;
        if (src_is_imm && (shreq || src_is_sp)) ill = 1;
        if (op_code == 2'd2 && (!src_is_imm || src_val > 32'd65535)) ill = 1;
        if ((dest_is_pc || src_is_sp) && (op_code != 2'd0 || src_is_imm || shreq || set_flags)) ill = 1;
        x = src_val;
        c = c_in;
        case (shift_type)
            3'd0: for (int i = 0; i < amt; i++) begin c = x[31]; x = x << 1; end
            3'd1: for (int i = 0; i < amt; i++) begin c = x[0];  x = x >> 1; end
            3'd2: for (int i = 0; i < amt; i++) begin c = x[0];  x = {x[31], x[31:1]}; end
            3'd3: for (int i = 0; i < amt; i++) begin c = x[0];  x = {x[0], x[31:1]}; end
            3'd4: begin oldc = c; c = x[0]; x = {oldc, x[31:1]}; end
            default: ;
        endcase
        if (src_is_imm || op_code == 2'd2) c = c_in;
        if (op_code == 2'd1) x = ~x;
        if (op_code == 2'd2) x = {16'h0, src_val[15:0]};
        if (ill) x = '0;
        e.res = x;
        e.ill = ill;
        e.v   = v_in;
        if (set_flags && !ill) begin
            e.n = x[31]; e.z = (x == 0); e.c = c;
        end else begin
            e.n = n_in; e.z = z_in; e.c = c_in;
        end
        e.br  = dest_is_pc && !ill;
        e.tgt = e.br ? (x & 32'hFFFF_FFFE) : 32'h0;
        return e;
    endfunction

    // Model register: advances with the clock like the unit's output stage.
    initial begin
        exp_now = '{valid: 0, res: 0, n: 0, z: 0, c: 0, v: 0, br: 0, ill: 0, tgt: 0, tag: "R13"};
        forever begin
            @(posedge clk);
            if (!rst_n) begin
                exp_now = '{valid: 0, res: 0, n: 0, z: 0, c: 0, v: 0, br: 0, ill: 0, tgt: 0, tag: "R13"};
            end else begin
                model_q.push_back(model_eval());
                if (model_q[0].valid) exp_now = model_q[0];
                else exp_now.valid = 0;
                void'(model_q.pop_front());
            end
        end
    end

    task automatic compare();
        bit bad;
        checks++;
        bad = (out_valid !== exp_now.valid);
        if (exp_now.valid)
            bad = bad || result !== exp_now.res || flag_n !== exp_now.n || flag_z !== exp_now.z ||
                  flag_c !== exp_now.c || flag_v !== exp_now.v || branch_req !== exp_now.br ||
                  branch_tgt !== exp_now.tgt || illegal !== exp_now.ill;
        if (bad) begin
            errors++;
            $display("FAIL %s: got v=%0b res=%h nzcv=%b%b%b%b br=%b tgt=%h ill=%b exp v=%0b res=%h nzcv=%b%b%b%b br=%b tgt=%h ill=%b",
                exp_now.tag, out_valid, result, flag_n, flag_z, flag_c, flag_v, branch_req, branch_tgt, illegal,
                exp_now.valid, exp_now.res, exp_now.n, exp_now.z, exp_now.c, exp_now.v, exp_now.br, exp_now.tgt, exp_now.ill);
        end
    endtask

    task automatic send(input string tag, input logic [1:0] op, input bit imm, input bit sp,
                        input logic [31:0] src, input logic [2:0] st, input bit sfr,
                        input logic [4:0] simm, input logic [31:0] sreg, input bit sf,
                        input bit cin, input bit vin, input bit pc);
        @(negedge clk);
        compare();
        cur_tag = tag; op_valid = 1; op_code = op; src_is_imm = imm; src_is_sp = sp;
        src_val = src; shift_type = st; shift_from_reg = sfr; shift_imm = simm;
        shift_reg = sreg; set_flags = sf; c_in = cin; v_in = vin; dest_is_pc = pc;
        n_in = ~src[31]; z_in = src[0];
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare();
            op_valid = 0; cur_tag = "R13";
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R13: reset clears every output
        checks++;
        if (out_valid !== 0 || result !== 0 || flag_n !== 0 || flag_z !== 0 || flag_c !== 0 ||
            flag_v !== 0 || branch_req !== 0 || branch_tgt !== 0 || illegal !== 0) begin
            errors++;
            $display("FAIL R13: reset outputs v=%b res=%h br=%b ill=%b exp all 0", out_valid, result, branch_req, illegal);
        end
        rst_n = 1;
        idle(2);
        //   tag    op  imm sp src            st sfr simm sreg          sf c v pc
        send("R1", 0, 1, 0, 32'h0000FA05, 0, 0, 0, 0,             0, 1, 0, 0);
        send("R1", 0, 0, 0, 32'h12345678, 0, 0, 0, 0,             1, 1, 1, 0);
        send("R2", 1, 1, 0, 32'h0000000F, 0, 0, 0, 0,             1, 0, 0, 0);
        send("R2", 1, 0, 0, 32'h00FF0000, 1, 0, 4, 0,             1, 0, 0, 0);
        send("R3", 2, 1, 0, 32'h0000FFFF, 0, 0, 0, 0,             1, 1, 0, 0);
        send("R3", 2, 1, 0, 32'h00010000, 0, 0, 0, 0,             1, 0, 0, 0);
        send("R3", 2, 0, 0, 32'h00000012, 0, 0, 0, 0,             0, 0, 0, 0);
        send("R4", 0, 0, 0, 32'h80000001, 0, 0, 1, 0,             1, 0, 0, 0);
        send("R4", 0, 0, 0, 32'h00000001, 0, 1, 0, 32'd32,        1, 0, 0, 0);
        send("R4", 0, 0, 0, 32'hFFFFFFFF, 0, 1, 0, 32'd33,        1, 1, 0, 0);
        send("R4", 0, 0, 0, 32'h80000000, 1, 1, 0, 32'd32,        1, 0, 0, 0);
        send("R4", 0, 0, 0, 32'hC0000000, 1, 0, 31, 0,            1, 0, 0, 0);
        send("R4", 0, 0, 0, 32'hFFFFFFFF, 1, 1, 0, 32'd200,       1, 1, 0, 0);
        send("R5", 0, 0, 0, 32'h80000010, 2, 0, 4, 0,             1, 0, 0, 0);
        send("R5", 0, 0, 0, 32'h80000000, 2, 1, 0, 32'd40,        1, 0, 0, 0);
        send("R5", 0, 0, 0, 32'h7FFFFFFF, 2, 1, 0, 32'd32,        1, 1, 0, 0);
        send("R6", 0, 0, 0, 32'h80000001, 3, 1, 0, 32'd64,        1, 0, 0, 0);
        send("R6", 0, 0, 0, 32'h000000F1, 3, 1, 0, 32'd8,         1, 0, 0, 0);
        send("R6", 0, 0, 0, 32'h00000002, 4, 0, 0, 0,             1, 1, 0, 0);
        send("R7", 0, 0, 0, 32'h0000000F, 0, 1, 0, 32'hABCD0104,  1, 0, 0, 0);
        send("R9", 0, 0, 0, 32'h0000000F, 0, 1, 0, 32'hFFFFFF00,  1, 1, 0, 0);
        send("R9", 0, 1, 0, 32'h80000000, 0, 0, 0, 0,             1, 1, 0, 0);
        send("R10", 0, 0, 0, 32'h00000000, 1, 0, 3, 0,            1, 0, 1, 0);
        send("R8", 0, 0, 0, 32'h00000000, 0, 0, 0, 0,             1, 1, 0, 0);
        send("R11", 0, 0, 0, 32'h00008001, 0, 0, 0, 0,            0, 0, 0, 1);
        send("R11", 0, 0, 1, 32'h20001000, 0, 0, 0, 0,            0, 0, 0, 0);
        send("R12", 0, 0, 0, 32'h00008001, 0, 0, 0, 0,            1, 0, 0, 1);
        send("R12", 0, 0, 1, 32'h20001000, 0, 0, 2, 0,            0, 0, 0, 0);
        send("R12", 1, 0, 0, 32'h00000004, 0, 0, 0, 0,            0, 0, 0, 1);
        send("R12", 0, 0, 0, 32'h00000004, 5, 0, 0, 0,            1, 1, 0, 0);
        send("R12", 3, 0, 0, 32'h00000004, 0, 0, 0, 0,            1, 1, 0, 0);
        send("R12", 0, 1, 0, 32'h00000004, 0, 0, 1, 0,            1, 1, 0, 0);
        idle(2);
        for (int k = 0; k < 600; k++) begin
            logic [31:0] sreg;
            int pick;
            pick = $urandom_range(0, 7);
            case (pick)
                0: sreg = 32'd0;  1: sreg = 32'd1;  2: sreg = 32'd31; 3: sreg = 32'd32;
                4: sreg = 32'd33; 5: sreg = 32'd64; 6: sreg = 32'd255;
                default: sreg = $urandom_range(0, 255);
            endcase
            sreg[31:8] = 24'($urandom);
            send("R8", 2'($urandom_range(0, 3)), ($urandom_range(0, 3) == 0), ($urandom_range(0, 9) == 0),
                 ($urandom_range(0, 4) == 0) ? 32'($urandom_range(0, 65535)) : $urandom,
                 3'($urandom_range(0, 5)), 1'($urandom), 5'($urandom), sreg, 1'($urandom),
                 1'($urandom), 1'($urandom), ($urandom_range(0, 7) == 0));
            if ($urandom_range(0, 9) == 0) idle(1);
        end
        idle(3);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R13: watchdog expired, got no end, exp end of stimulus");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule